// File: doc/BRIEF.md
# Selectable Accumulator Rounding Unit

This block takes a signed 36-bit fixed-point accumulator value and rounds it to single precision. The cut sits between bit 16 and bit 15. Bits 15..0 are the discarded fraction. The kept part is bits 35..16: a 4-bit extension on top of a 16-bit word. The result is produced in two forms:

- a full-width accumulator with the fraction forced to zero;
- a 16-bit word that an optional output limiter can clamp.

A fraction of exactly one half is resolved in one of two ways. Convergent mode rounds it toward an even kept part. Two's-complement mode always rounds it upward. A mode register selects between them. A value written to that register is only used after two instruction steps have passed, as marked by the `instr_step` strobe. Until then the old mode stays in force.

Each valid operand gives one registered result one cycle later, together with `out_valid`. The saturation flag pulses alongside a result whose 16-bit word was clamped.

Top module: `acc_round_unit`

## Requirements
- R1: When the fraction `in_acc[15:0]` is above 0x8000, bits 35..16 of `out_acc` equal `in_acc[35:16] + 1`. When the fraction is below 0x8000, they equal `in_acc[35:16]`. The sum wraps modulo 2^20.
- R2: In convergent mode with a fraction of exactly 0x8000, the kept part is incremented only when `in_acc[16]` is 1. When `in_acc[16]` is 0 it is left unchanged.
- R3: In two's-complement mode with a fraction of exactly 0x8000, the kept part is always incremented.
- R4: The mode encoding is `mode_wr_val` = 0 for convergent and 1 for two's-complement. After reset the active mode is convergent.
- R5: A mode written with `mode_wr_en` becomes active at the clock edge of the second `instr_step` pulse counted from the write (a step in the write cycle counts). Operands presented before that edge are rounded with the previous mode. Cycles without `instr_step` never change the active mode.
- R6: Bits 15..0 of `out_acc` are zero in every valid result.
- R7: When `out_sat` is low, `out_word` equals bits 31..16 of the rounded value.
- R8: When `limit_en` is high and the rounded kept part, read as a signed 20-bit number, lies outside -32768..32767, the following happens:
  - `out_word` becomes 0x7FFF for positive overflow and 0x8000 for negative overflow;
  - `out_sat` is 1 for that result;
  - `out_acc` still carries the unclamped value.
- R9: When `limit_en` is low, `out_sat` stays 0 and `out_word` is never clamped.
- R10: `out_valid` and the result appear exactly one cycle after an `in_valid` cycle. In a cycle after one without `in_valid`, both `out_valid` and `out_sat` are 0.
- R11: During reset, `out_valid`, `out_acc`, `out_word` and `out_sat` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_acc | input | 36 | Signed accumulator operand |
| limit_en | input | 1 | Output limiter enable for this operand |
| mode_wr_en | input | 1 | Write strobe for the rounding mode register |
| mode_wr_val | input | 1 | Mode to write: 0 convergent, 1 two's-complement |
| instr_step | input | 1 | One pulse per instruction; advances the mode delay |
| out_valid | output | 1 | Result valid |
| out_acc | output | 36 | Rounded accumulator, fraction cleared |
| out_word | output | 16 | Rounded single-precision word, limited if enabled |
| out_sat | output | 1 | Word was clamped by the limiter |

## Verification
The rounding path is swept with fourteen kept parts crossed with twenty-two fractions, in both modes and with the limiter on and off.

- **Kept parts:** zero, small odd and even values, minus one, and values on both sides of the 16-bit signed boundary.
- **Fractions:** 0x0000, 0x0001, 0x7FFF, 0x8000, 0x8001, 0xFFFF and a stride across the range.

The exact-half fraction on odd and even kept parts separates convergent from two's-complement resolution. The values one below and one above half show that the plain up/down rule is not confused with the tie rule. Kept parts such as 0x07FFF with a fraction above half overflow only because of rounding, which shows that the limiter acts on the rounded value. A separate sequence writes the mode and probes a half-way value after zero, one and two steps, so the exact activation edge is pinned.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;

    typedef enum logic {
        RND_CONV = 1'b0,
        RND_TWOS = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/arm_mode_delay.sv
module arm_mode_delay #(
    parameter int DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  acc_round_pkg::rnd_mode_e wr_mode,
    input  logic                     step,
    output acc_round_pkg::rnd_mode_e mode_act
);
    import acc_round_pkg::*;

    typedef struct packed {
        rnd_mode_e              req;
        logic [DEPTH-1:0]       pipe;
    } dly_s;

    dly_s st_d, st_q;
    rnd_mode_e req_now;

    always_comb begin
        st_d    = st_q;
        req_now = wr_en ? wr_mode : st_q.req;
        st_d.req = req_now;
        if (step) begin
            st_d.pipe[0] = req_now;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.pipe[i] = st_q.pipe[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req  <= RND_CONV;
            st_q.pipe <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_act = rnd_mode_e'(st_q.pipe[DEPTH-1]);

endmodule

// File: rtl/arm_round_core.sv
module arm_round_core #(
    parameter int ACC_W  = 36,
    parameter int FRAC_W = 16,
    localparam int HI_W  = ACC_W - FRAC_W
) (
    input  logic [ACC_W-1:0]         acc,
    input  acc_round_pkg::rnd_mode_e mode,
    output logic [HI_W-1:0]          hi_rnd
);
    import acc_round_pkg::*;

    localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

    logic [FRAC_W-1:0] frac;
    logic [HI_W-1:0]   kept;
    logic              above, at_half, bump;

    always_comb begin
        frac    = acc[FRAC_W-1:0];
        kept    = acc[ACC_W-1:FRAC_W];
        above   = frac > HALF;
        at_half = frac == HALF;
        bump    = above | (at_half & ((mode == RND_TWOS) | kept[0]));
        hi_rnd  = kept + HI_W'(bump);
    end

endmodule

// File: rtl/arm_limiter.sv
module arm_limiter #(
    parameter int HI_W   = 20,
    parameter int WORD_W = 16
) (
    input  logic [HI_W-1:0]   hi,
    input  logic              en,
    output logic [WORD_W-1:0] word,
    output logic              sat
);
    localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_MIN = {1'b1, {(WORD_W-1){1'b0}}};

    logic [HI_W-WORD_W:0] top_bits;
    logic                 fits;

    always_comb begin
        top_bits = hi[HI_W-1:WORD_W-1];
        fits     = (&top_bits) | ~(|top_bits);
        sat      = en & ~fits;
        if (sat) begin
            word = hi[HI_W-1] ? NEG_MIN : POS_MAX;
        end else begin
            word = hi[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit #(
    parameter int ACC_W     = 36,
    parameter int FRAC_W    = 16,
    parameter int WORD_W    = 16,
    parameter int MODE_DLY  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  in_acc,
    input  logic              limit_en,
    input  logic              mode_wr_en,
    input  logic              mode_wr_val,
    input  logic              instr_step,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_acc,
    output logic [WORD_W-1:0] out_word,
    output logic              out_sat
);
    import acc_round_pkg::*;

    localparam int HI_W = ACC_W - FRAC_W;

    typedef struct packed {
        logic              vld;
        logic [ACC_W-1:0]  acc;
        logic [WORD_W-1:0] word;
        logic              sat;
    } res_s;

    rnd_mode_e         mode_act;
    logic [HI_W-1:0]   hi_rnd;
    logic [WORD_W-1:0] word_c;
    logic              sat_c;
    res_s              res_d, res_q;

    arm_mode_delay #(.DEPTH(MODE_DLY)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr_en),
        .wr_mode  (rnd_mode_e'(mode_wr_val)),
        .step     (instr_step),
        .mode_act (mode_act)
    );

    arm_round_core #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_core (
        .acc    (in_acc),
        .mode   (mode_act),
        .hi_rnd (hi_rnd)
    );

    arm_limiter #(.HI_W(HI_W), .WORD_W(WORD_W)) u_lim (
        .hi   (hi_rnd),
        .en   (limit_en),
        .word (word_c),
        .sat  (sat_c)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.sat = in_valid & sat_c;
        if (in_valid) begin
            res_d.acc  = {hi_rnd, {FRAC_W{1'b0}}};
            res_d.word = word_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_acc   = res_q.acc;
    assign out_word  = res_q.word;
    assign out_sat   = res_q.sat;

endmodule

// File: rtl/acc_round_chk.sv
module acc_round_chk #(
    parameter int ACC_W  = 36,
    parameter int FRAC_W = 16,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              limit_en,
    input logic              instr_step,
    input logic              mode_act,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_acc,
    input logic [WORD_W-1:0] out_word,
    input logic              out_sat
);
    localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_MIN = {1'b1, {(WORD_W-1){1'b0}}};

    AST_FRAC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_acc[FRAC_W-1:0] == '0)); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_sat)); // R10
    AST_NO_SAT_UNLIMITED: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_en |=> !out_sat); // R9
    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_word == POS_MAX || out_word == NEG_MIN)); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_step |=> $stable(mode_act)); // R5

endmodule

bind acc_round_unit acc_round_chk #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .limit_en   (limit_en),
    .instr_step (instr_step),
    .mode_act   (mode_act),
    .out_valid  (out_valid),
    .out_acc    (out_acc),
    .out_word   (out_word),
    .out_sat    (out_sat)
);

// File: tb/acc_round_unit_tb.sv
module acc_round_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_acc = '0;
    logic        limit_en = 1'b0;
    logic        mode_wr_en = 1'b0;
    logic        mode_wr_val = 1'b0;
    logic        instr_step = 1'b0;
    logic        out_valid;
    logic [35:0] out_acc;
    logic [15:0] out_word;
    logic        out_sat;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    acc_round_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .limit_en(limit_en), .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .instr_step(instr_step), .out_valid(out_valid), .out_acc(out_acc),
        .out_word(out_word), .out_sat(out_sat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drives one operand, checks the result one cycle later and the idle cycle after
    task automatic run(input logic [35:0] a, input logic lim, input logic md);
        longint v, q;
        logic   xsat;
        logic [15:0] xw;
        string  tag;
        v = longint'($signed(a));
        q = (v + 64'sd32768) >>> 16;
        if (!md && a[15:0] == 16'h8000 && q[0]) q = q - 1;
        xsat = lim && (q > 32767 || q < -32768);
        xw   = xsat ? (q < 0 ? 16'h8000 : 16'h7FFF) : q[15:0];
        if (a[15:0] == 16'h8000) tag = md ? "R3" : "R2";
        else tag = "R1";
        @(negedge clk);
        in_valid = 1'b1; in_acc = a; limit_en = lim;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 valid", {63'd0, out_valid}, 64'd1);
        chk({tag, " acc hi"}, {44'd0, out_acc[35:16]}, {44'd0, q[19:0]});
        chk("R6 frac", {48'd0, out_acc[15:0]}, 64'd0);
        chk(xsat ? "R8 word" : "R7 word", {48'd0, out_word}, {48'd0, xw});
        chk(lim ? "R8 sat" : "R9 sat", {63'd0, out_sat}, {63'd0, xsat});
        @(negedge clk);
        chk("R10 idle", {62'd0, out_valid, out_sat}, 64'd0);
    endtask

    task automatic wr_mode(input logic m);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_val = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic step_once();
        @(negedge clk);
        instr_step = 1'b1;
        @(negedge clk);
        instr_step = 1'b0;
    endtask

    function automatic logic [19:0] hi_of(input int i);
        logic [19:0] t [14] = '{20'h00000, 20'h00001, 20'h00002, 20'h00003,
                                20'h07FFE, 20'h07FFF, 20'h08000, 20'h0FFFF,
                                20'hFFFFF, 20'hFFFFE, 20'hF8000, 20'hF7FFF,
                                20'h80000, 20'h7FFF0};
        return t[i];
    endfunction

    function automatic logic [15:0] lo_of(input int i);
        logic [15:0] s [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
        if (i < 6) return s[i];
        return 16'((i - 6) * 16'h1357);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset", {24'd0, out_valid, out_acc, out_word, out_sat}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset mode is convergent: half on even kept part stays
        run(36'h0_0002_8000, 1'b0, 1'b0);

        // R5: write two's-complement, probe after 0, 1, 2 steps
        wr_mode(1'b1);
        run(36'h0_0004_8000, 1'b0, 1'b0);
        step_once();
        run(36'h0_0004_8000, 1'b0, 1'b0);
        step_once();
        run(36'h0_0004_8000, 1'b0, 1'b1);
        // R5: write back to convergent with step in the same cycle
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_val = 1'b0; instr_step = 1'b1;
        @(negedge clk);
        mode_wr_en = 1'b0; instr_step = 1'b0;
        run(36'h0_0006_8000, 1'b0, 1'b1);
        step_once();
        run(36'h0_0006_8000, 1'b0, 1'b0);

        // sweep: mode x limiter x kept part x fraction
        for (int m = 0; m < 2; m++) begin
            wr_mode(m[0]);
            step_once();
            step_once();
            for (int l = 0; l < 2; l++) begin
                for (int h = 0; h < 14; h++) begin
                    for (int f = 0; f < 22; f++) begin
                        run({hi_of(h), lo_of(f)}, l[0], m[0]);
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule